// File: doc/BRIEF.md
# Dual-Path Divider Configuration Loader

This block holds the feedback (M) and output (N) divider words of a frequency synthesizer and a small test-select word (T). The divider words can arrive on either of two paths. On the parallel path the M and N words are presented on input pins and a strobe decides what happens to them. While the strobe is low, the active words follow the pins. When the strobe rises, the words are frozen.

The serial path has three slow pins: a bit clock, a data line and a load pulse. Each bit is shifted into a frame register of T+N+M bits. When the load pulse falls, the whole frame is moved into the active words. The serial pins are treated as asynchronous. They are synchronized into the system clock and edge-detected there.

The test-select word can only be written through the serial path. It reads as zero whenever the parallel strobe is low, so that a quiet test setting is restored each time the parallel path is opened.

Top module: `dual_path_div_cfg`

## Requirements
- R1: A synchronous reset clears the T word and the serial frame register to zero. It also loads the held M and N words from the parallel inputs. After reset, a frame transfer with no bits shifted in gives M=0, N=0 and T=0.
- R2: While the parallel strobe is low, `m_o` and `n_o` equal `par_m_i` and `par_n_i` in the same cycle.
- R3: When the parallel strobe rises, M and N keep the values the parallel inputs had in the last cycle before the rise. Later changes on the parallel inputs have no effect while the strobe stays high.
- R4: `t_o` is zero whenever the parallel strobe is low. A T value loaded earlier does not return when the strobe rises again.
- R5: Each rising edge of the serial bit clock shifts the data bit into bit 0 of the frame, so the first bit sent ends in the top bit. The frame holds T in bits [13:11], N in bits [10:9] and M in bits [8:0]. Each field is sent most significant bit first, in the order T, N, M. A falling edge of the load pulse copies these fields to `t_o`, `n_o` and `m_o`.
- R6: A rising edge of the serial load pulse changes no output.
- R7: Serial bit-clock edges that occur while the parallel strobe is low leave the frame register unchanged.
- R8: A falling edge of the serial load pulse while the parallel strobe is low has no effect. The outputs keep following the parallel inputs, and the parallel value is the one captured when the strobe rises.
- R9: When more than 14 bits are shifted in before a transfer, only the last 14 bits sent are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_m_i | input | 9 | Parallel M divider word |
| par_n_i | input | 2 | Parallel N divider word |
| par_strobe_i | input | 1 | Parallel strobe: low = follow the inputs, rising = capture them |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, sampled on the bit clock's rising edge |
| ser_ld_i | input | 1 | Serial load pulse; its falling edge transfers the frame |
| m_o | output | 9 | Active M divider word |
| n_o | output | 2 | Active N divider word |
| t_o | output | 3 | Active test-select word |

## Verification
The bench builds the block with its default widths: a 9-bit M, a 2-bit N, a 3-bit T and two synchronizer stages. With these widths, every field boundary of the 14-bit frame lines up with a bit position stated in the requirements, and a serial bit or load pulse reaches the outputs within four system clocks. Because of this, the bench can hold each serial level for a fixed number of clocks and predict the exact outputs. It can also reach overlong streams, bits sent while the strobe is low, transfers while the strobe is low, and strobe toggles mixed at random between frames.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    // Default field widths of the divider configuration
    localparam int DEF_M_W    = 9;
    localparam int DEF_N_W    = 2;
    localparam int DEF_T_W    = 3;
    localparam int DEF_SYNC_N = 2;

    // Bit positions of the three serial pins in the synchronized bundle
    localparam int PIN_LD  = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_CLK = 2;
    localparam int PIN_CNT = 3;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef logic [W-1:0] word_t;

    word_t chain_d [STAGES];
    word_t chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
    parameter int SR_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            sclk_s_i,
    input  logic            sdat_s_i,
    output logic [SR_W-1:0] frame_o
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            sclk_prev;
    } shift_t;

    shift_t st_d, st_q;
    logic   fire;

    always_comb begin
        fire            = sclk_s_i & ~st_q.sclk_prev & en_i;
        st_d            = st_q;
        st_d.sclk_prev  = sclk_s_i;
        if (fire) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdat_s_i};
        end
        if (rst) begin
            st_d.sr        = '0;
            st_d.sclk_prev = sclk_s_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign frame_o = st_q.sr;

    // R7
    no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(st_q.sr));

    // R5
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (st_q.sr[0] == $past(sdat_s_i)) &&
                 (st_q.sr[SR_W-1:1] == $past(st_q.sr[SR_W-2:0])));
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe_i,
    input  logic [M_W-1:0]       par_m_i,
    input  logic [N_W-1:0]       par_n_i,
    input  logic                 sld_s_i,
    input  logic [T_W+N_W+M_W-1:0] frame_i,
    output logic [M_W-1:0]       m_o,
    output logic [N_W-1:0]       n_o,
    output logic [T_W-1:0]       t_o
);
    localparam int SR_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
        logic           sld_prev;
    } hold_t;

    hold_t st_d, st_q;
    logic  xfer;

    always_comb begin
        xfer          = st_q.sld_prev & ~sld_s_i & strobe_i;
        st_d          = st_q;
        st_d.sld_prev = sld_s_i;
        if (!strobe_i) begin
            // transparent phase: track the pins, keep test quiet
            st_d.m = par_m_i;
            st_d.n = par_n_i;
            st_d.t = '0;
        end else if (xfer) begin
            st_d.t = frame_i[SR_W-1 -: T_W];
            st_d.n = frame_i[M_W +: N_W];
            st_d.m = frame_i[M_W-1:0];
        end
        if (rst) begin
            st_d.m        = par_m_i;
            st_d.n        = par_n_i;
            st_d.t        = '0;
            st_d.sld_prev = sld_s_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign m_o = strobe_i ? st_q.m : par_m_i;
    assign n_o = strobe_i ? st_q.n : par_n_i;
    assign t_o = strobe_i ? st_q.t : '0;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !xfer) |=> ($stable(st_q.m) && $stable(st_q.n) && $stable(st_q.t)));

    // R4
    t_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> (st_q.t == '0));

    // R5
    xfer_load_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (st_q.m == $past(frame_i[M_W-1:0])) &&
                 (st_q.n == $past(frame_i[M_W +: N_W])) &&
                 (st_q.t == $past(frame_i[SR_W-1 -: T_W])));
endmodule

// File: rtl/dual_path_div_cfg.sv
module dual_path_div_cfg
    import divcfg_pkg::*;
#(
    parameter int M_W    = DEF_M_W,
    parameter int N_W    = DEF_N_W,
    parameter int T_W    = DEF_T_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  logic           par_strobe_i,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_ld_i,
    output logic [M_W-1:0] m_o,
    output logic [N_W-1:0] n_o,
    output logic [T_W-1:0] t_o
);
    localparam int SR_W = T_W + N_W + M_W;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic [SR_W-1:0]    frame;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_CLK] = ser_clk_i;
        pins_raw[PIN_DAT] = ser_dat_i;
        pins_raw[PIN_LD]  = ser_ld_i;
    end

    divcfg_sync #(.W(PIN_CNT), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    divcfg_shift #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en_i     (par_strobe_i),
        .sclk_s_i (pins_s[PIN_CLK]),
        .sdat_s_i (pins_s[PIN_DAT]),
        .frame_o  (frame)
    );

    divcfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (par_strobe_i),
        .par_m_i  (par_m_i),
        .par_n_i  (par_n_i),
        .sld_s_i  (pins_s[PIN_LD]),
        .frame_i  (frame),
        .m_o      (m_o),
        .n_o      (n_o),
        .t_o      (t_o)
    );
endmodule

// File: tb/tb_dual_path_div_cfg.sv
module tb_dual_path_div_cfg;
    localparam int CLK_PERIOD = 10;
    localparam int SR_W = 14;

    logic       clk = 0;
    logic       rst = 1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       strobe = 0;
    logic       sclk = 0, sdat = 0, sld = 0;
    logic [8:0] m_o;
    logic [1:0] n_o;
    logic [2:0] t_o;

    dual_path_div_cfg dut (
        .clk(clk), .rst(rst), .par_m_i(par_m), .par_n_i(par_n),
        .par_strobe_i(strobe), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_ld_i(sld), .m_o(m_o), .n_o(n_o), .t_o(t_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [8:0]      em = '0;
    logic [1:0]      en = '0;
    logic [2:0]      et = '0;
    logic [SR_W-1:0] esr = '0;

    function automatic logic [8:0] exp_m();
        return strobe ? em : par_m;
    endfunction
    function automatic logic [1:0] exp_n();
        return strobe ? en : par_n;
    endfunction
    function automatic logic [2:0] exp_t();
        return strobe ? et : 3'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        chk(m_o == exp_m(), {req, " m"}, int'(m_o), int'(exp_m()));
        chk(n_o == exp_n(), {req, " n"}, int'(n_o), int'(exp_n()));
        chk(t_o == exp_t(), {req, " t"}, int'(t_o), int'(exp_t()));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_par(input logic [8:0] m, input logic [1:0] n);
        @(negedge clk);
        par_m = m;
        par_n = n;
    endtask

    task automatic rise_strobe();
        @(negedge clk);
        strobe = 1;
        em = par_m; en = par_n; et = '0;
    endtask

    task automatic fall_strobe();
        @(negedge clk);
        strobe = 0;
        et = '0;
    endtask

    task automatic send_bit(input logic b);
        sdat = b;
        tick(3);
        sclk = 1;
        tick(4);
        sclk = 0;
        tick(3);
        if (strobe) esr = {esr[SR_W-2:0], b};
    endtask

    task automatic send_word(input logic [SR_W-1:0] f);
        for (int i = SR_W-1; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_load();
        sld = 1;
        tick(5);
        check_outs("R6");   // rising load edge changes nothing
        sld = 0;
        tick(5);
        if (strobe) begin
            et = esr[13:11]; en = esr[10:9]; em = esr[8:0];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1..: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        par_m = 9'h0A5; par_n = 2'd3;
        tick(4);
        rst = 0;
        tick(1);
        // R1: reset state, outputs follow pins, T zero
        check_outs("R1");
        rise_strobe();
        tick(2);
        check_outs("R1");
        pulse_load();
        // R1: cleared frame gives zeros
        chk(m_o == 9'd0 && n_o == 2'd0 && t_o == 3'd0, "R1 empty frame",
            int'({t_o, n_o, m_o}), 0);

        // R2: transparency while strobe low
        fall_strobe();
        for (int i = 0; i < 6; i++) begin
            set_par(9'($urandom), 2'($urandom));
            #1;
            check_outs("R2");
        end

        // R3: capture on strobe rise
        set_par(9'h1C3, 2'd2);
        rise_strobe();
        set_par(9'h03C, 2'd1);
        tick(3);
        chk(m_o == 9'h1C3, "R3 m held", int'(m_o), 9'h1C3);
        chk(n_o == 2'd2,   "R3 n held", int'(n_o), 2);

        // R5: directed frame T=5 N=2 M=0x19A
        send_word({3'b101, 2'b10, 9'h19A});
        pulse_load();
        chk(t_o == 3'd5,   "R5 t", int'(t_o), 5);
        chk(n_o == 2'd2,   "R5 n", int'(n_o), 2);
        chk(m_o == 9'h19A, "R5 m", int'(m_o), 9'h19A);

        // R4: T forced to zero while strobe low, not restored on rise
        fall_strobe();
        tick(1);
        chk(t_o == 3'd0, "R4 low", int'(t_o), 0);
        rise_strobe();
        tick(2);
        chk(t_o == 3'd0, "R4 reopen", int'(t_o), 0);

        // R7: bits sent while strobe low are ignored
        send_word({3'b011, 2'b01, 9'h0F0});
        fall_strobe();
        send_word({3'b100, 2'b11, 9'h155});
        rise_strobe();
        pulse_load();
        chk({t_o, n_o, m_o} == {3'b011, 2'b01, 9'h0F0}, "R7 old frame kept",
            int'({t_o, n_o, m_o}), int'({3'b011, 2'b01, 9'h0F0}));
        check_outs("R7");

        // R8: load pulse while strobe low ignored
        fall_strobe();
        set_par(9'h111, 2'd0);
        pulse_load();
        #1;
        chk(m_o == 9'h111 && t_o == 3'd0, "R8 low", int'({t_o, m_o}), int'({3'd0, 9'h111}));
        rise_strobe();
        tick(2);
        chk(m_o == 9'h111, "R8 captured parallel", int'(m_o), 9'h111);
        chk(n_o == 2'd0,   "R8 n", int'(n_o), 0);

        // R9: overlong stream keeps the last 14 bits
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_word({3'b010, 2'b00, 9'h0AB});
        pulse_load();
        chk({t_o, n_o, m_o} == {3'b010, 2'b00, 9'h0AB}, "R9",
            int'({t_o, n_o, m_o}), int'({3'b010, 2'b00, 9'h0AB}));

        // random mix
        for (int k = 0; k < 40; k++) begin
            case ($urandom % 4)
                0: begin
                    set_par(9'($urandom), 2'($urandom));
                    #1;
                    check_outs(strobe ? "R3" : "R2");
                end
                1: begin
                    if (strobe) fall_strobe(); else rise_strobe();
                    tick(2);
                    check_outs("R4");
                end
                2: begin
                    for (int b = 0; b < 14 + int'($urandom % 5); b++)
                        send_bit(1'($urandom));
                    check_outs("R7");
                end
                default: begin
                    pulse_load();
                    check_outs(strobe ? "R5" : "R8");
                end
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule